// File: doc/BRIEF.md
# HDLC Transmit Block Pool with Underrun Abort

This block sits between a host processor and a bit-level HDLC framer on the send side. The host loads frame payload in blocks of at most `BLOCK_BYTES` bytes into a small on-chip store. It then commits each block. A commit either leaves the frame open for more blocks or marks the block as the closing one. The first commit of a frame starts transmission. The framer pulls bytes one at a time with a valid/ready handshake. It is told which byte is the last of the frame, so that it can append the checksum and closing flag.

A level output tells the host when room for one more full block exists. If the framer asks for a byte in mid-frame, the store holds nothing committed, and no closing block was marked, the frame is lost. The block then pulses an abort request to the framer, raises an underrun interrupt, discards what is left of the frame and refuses new data. That lock lasts until the interrupt is acknowledged or a transmit reset is applied. The transmit reset also empties the store at any time. Framing, bit stuffing and checksum generation stay in the framer.

Top module: `hdlc_txpool`

## Requirements
- R1: After reset, `pool_ready` is 1 and `udr_irq`, `fr_valid`, `fr_last` and `fr_abort` are 0.
- R2: After a commit, `fr_valid` rises in the next cycle. Bytes leave on `fr_data` in the order they were written, one byte per cycle in which `fr_valid` and `fr_ready` are both 1. While `fr_ready` is 0, `fr_data` holds.
- R3: `fr_last` is 1 exactly while the final byte of a block committed with `blk_last`=1 is presented. Once that byte is taken, the frame is over: `fr_valid` goes to 0, and holding `fr_ready` high causes no abort.
- R4: A block holds at most `BLOCK_BYTES` bytes. Further writes before the commit are dropped.
- R5: `pool_ready` is 1 only while the committed bytes not yet taken by the framer number at most (`NUM_BLOCKS`-1)·`BLOCK_BYTES`. With the defaults, that means at most 32.
- R6: From the commit of a closing block until its last byte is taken, `pool_ready` is 0.
- R7: Underrun occurs when a frame is open, `fr_ready` is 1, no committed byte is left and no closing block was marked. In that case `fr_abort` is 1 for exactly the next cycle and `udr_irq` becomes 1.
- R8: While `udr_irq` is 1, `pool_ready` and `fr_valid` are 0, and byte writes and commits are ignored.
- R9: `udr_ack` clears `udr_irq` in the next cycle, which lifts the lock of R8.
- R10: `tx_reset` empties the store, including uncommitted bytes, ends any open frame and clears `udr_irq`. In the next cycle `pool_ready` is 1 and `fr_valid` is 0.
- R11: Byte writes and commits made while `pool_ready` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Host writes one byte into the open block |
| cpu_wr_data | input | DATA_W | Byte written by the host |
| blk_commit | input | 1 | Host hands the open block to the framer side |
| blk_last | input | 1 | With `blk_commit`: this block closes the frame |
| tx_reset | input | 1 | Flush the store, end the frame, clear the lock |
| udr_ack | input | 1 | Acknowledge the underrun interrupt |
| pool_ready | output | 1 | Room for another full block may be written |
| udr_irq | output | 1 | Underrun interrupt, level |
| fr_ready | input | 1 | Framer asks for the next byte |
| fr_valid | output | 1 | A committed byte is presented |
| fr_data | output | DATA_W | Presented byte |
| fr_last | output | 1 | Presented byte closes the frame |
| fr_abort | output | 1 | One-cycle request to send an abort sequence |

## Verification
A commit, a transmit reset and an acknowledge each take effect in the cycle after the edge that registers them. An underrun shows on `fr_abort` and `udr_irq` one edge after the cycle in which `fr_ready` met an empty open frame, and `fr_abort` drops one edge later. Inputs are driven and outputs compared at the falling edge. Each comparison therefore sees the state after exactly the number of rising edges stated above, and a reference queue in the bench predicts every byte. The sweep covers every block length from one byte to a full block, plus overfill, a two-block store, and lockout with both ways out.

// File: rtl/txpool_pkg.sv
package txpool_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/txpool_store.sv
module txpool_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       pop,
  input  logic                       flush,
  output logic [DATA_W-1:0]          rdata,
  output logic [$clog2(DEPTH+1)-1:0] used
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = bump(wp_q);
      if (pop)  rp_d = bump(rp_q);
      cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign used  = cnt_q;
endmodule

// File: rtl/txpool_ctrl.sv
module txpool_ctrl
  import txpool_pkg::*;
#(
  parameter int BLOCK = 32,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_wr,
  input  logic                       cmd_commit,
  input  logic                       cmd_last,
  input  logic                       irq_ack,
  input  logic                       xres,
  input  logic                       tx_ready,
  input  logic [$clog2(DEPTH+1)-1:0] used,
  output logic                       push,
  output logic                       pop,
  output logic                       flush,
  output logic                       pool_ready,
  output logic                       tx_valid,
  output logic                       tx_last,
  output logic                       tx_abort,
  output logic                       irq_udr
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int PND_W = $clog2(BLOCK+1);
  localparam logic [CNT_W-1:0] ROOM_LIM = CNT_W'(DEPTH - BLOCK);

  tx_state_e        st_q, st_d;
  logic [PND_W-1:0] pend_q, pend_d;
  logic             eom_q, eom_d;
  logic             irq_q, irq_d;
  logic             abt_q, abt_d;

  logic [CNT_W-1:0] cmt_cnt;
  logic             wr_ok, commit_ok, underrun;

  // Bytes already handed over = total stored minus the open block.
  assign cmt_cnt    = used - CNT_W'(pend_q);
  assign pool_ready = !irq_q && !eom_q && (cmt_cnt <= ROOM_LIM);
  assign wr_ok      = cpu_wr && !cmd_commit && !xres && pool_ready
                      && (pend_q < PND_W'(BLOCK));
  assign commit_ok  = cmd_commit && !xres && pool_ready && (pend_q != '0);
  assign tx_valid   = (st_q == TX_SEND) && (cmt_cnt != '0);
  assign tx_last    = tx_valid && eom_q && (cmt_cnt == CNT_W'(1));
  assign pop        = tx_valid && tx_ready && !xres;
  assign underrun   = (st_q == TX_SEND) && tx_ready && (cmt_cnt == '0)
                      && !eom_q && !xres && !commit_ok;
  assign push       = wr_ok;
  assign flush      = xres || underrun;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    eom_d  = eom_q;
    irq_d  = irq_q;
    abt_d  = 1'b0;
    if (xres) begin
      st_d   = TX_IDLE;
      pend_d = '0;
      eom_d  = 1'b0;
      irq_d  = 1'b0;
    end else if (underrun) begin
      st_d   = TX_IDLE;
      pend_d = '0;
      irq_d  = 1'b1;
      abt_d  = 1'b1;
    end else begin
      if (wr_ok) pend_d = pend_q + 1'b1;
      if (commit_ok) begin
        pend_d = '0;
        st_d   = TX_SEND;
        eom_d  = cmd_last;
      end
      if (pop && tx_last) begin
        st_d  = TX_IDLE;
        eom_d = 1'b0;
      end
      if (irq_ack) irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      pend_q <= '0;
      eom_q  <= 1'b0;
      irq_q  <= 1'b0;
      abt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      eom_q  <= eom_d;
      irq_q  <= irq_d;
      abt_q  <= abt_d;
    end
  end

  assign tx_abort = abt_q;
  assign irq_udr  = irq_q;
endmodule

// File: rtl/hdlc_txpool.sv
module hdlc_txpool #(
  parameter int DATA_W      = 8,
  parameter int BLOCK_BYTES = 32,
  parameter int NUM_BLOCKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              blk_commit,
  input  logic              blk_last,
  input  logic              tx_reset,
  input  logic              udr_ack,
  output logic              pool_ready,
  output logic              udr_irq,
  input  logic              fr_ready,
  output logic              fr_valid,
  output logic [DATA_W-1:0] fr_data,
  output logic              fr_last,
  output logic              fr_abort
);
  localparam int DEPTH = BLOCK_BYTES * NUM_BLOCKS;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic             push, pop, flush;
  logic [CNT_W-1:0] used;

  txpool_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (cpu_wr_data),
    .pop   (pop),
    .flush (flush),
    .rdata (fr_data),
    .used  (used)
  );

  txpool_ctrl #(.BLOCK(BLOCK_BYTES), .DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr_en),
    .cmd_commit (blk_commit),
    .cmd_last   (blk_last),
    .irq_ack    (udr_ack),
    .xres       (tx_reset),
    .tx_ready   (fr_ready),
    .used       (used),
    .push       (push),
    .pop        (pop),
    .flush      (flush),
    .pool_ready (pool_ready),
    .tx_valid   (fr_valid),
    .tx_last    (fr_last),
    .tx_abort   (fr_abort),
    .irq_udr    (udr_irq)
  );
endmodule

// File: rtl/hdlc_txpool_chk.sv
module hdlc_txpool_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_reset,
  input logic              udr_ack,
  input logic              pool_ready,
  input logic              udr_irq,
  input logic              fr_ready,
  input logic              fr_valid,
  input logic [DATA_W-1:0] fr_data,
  input logic              fr_last,
  input logic              fr_abort
);
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_abort |=> !fr_abort); // R7
  AST_ABORT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fr_abort |-> udr_irq); // R7
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fr_last |-> fr_valid); // R3
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_ready && !tx_reset) |=> (fr_valid && $stable(fr_data))); // R2
  AST_LOCK_NO_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    udr_irq |-> (!pool_ready && !fr_valid)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_irq && udr_ack) |=> !udr_irq); // R9
  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (pool_ready && !fr_valid && !udr_irq)); // R10
endmodule

bind hdlc_txpool hdlc_txpool_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_reset   (tx_reset),
  .udr_ack    (udr_ack),
  .pool_ready (pool_ready),
  .udr_irq    (udr_irq),
  .fr_ready   (fr_ready),
  .fr_valid   (fr_valid),
  .fr_data    (fr_data),
  .fr_last    (fr_last),
  .fr_abort   (fr_abort)
);

// File: tb/hdlc_txpool_test.sv
`timescale 1ns/1ps
module hdlc_txpool_test;
  localparam int BLK = 32;
  localparam int NB  = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_wr_en, blk_commit, blk_last, tx_reset, udr_ack, fr_ready;
  logic [7:0] cpu_wr_data;
  logic       pool_ready, udr_irq, fr_valid, fr_last, fr_abort;
  logic [7:0] fr_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] q[$];

  always #2.5 clk = ~clk;

  hdlc_txpool #(.DATA_W(8), .BLOCK_BYTES(BLK), .NUM_BLOCKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .blk_commit(blk_commit), .blk_last(blk_last), .tx_reset(tx_reset),
    .udr_ack(udr_ack), .pool_ready(pool_ready), .udr_irq(udr_irq),
    .fr_ready(fr_ready), .fr_valid(fr_valid), .fr_data(fr_data),
    .fr_last(fr_last), .fr_abort(fr_abort)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    cpu_wr_en = 1'b1; cpu_wr_data = b;
    tick();
    cpu_wr_en = 1'b0;
  endtask

  task automatic commit(input logic last);
    blk_commit = 1'b1; blk_last = last;
    tick();
    blk_commit = 1'b0; blk_last = 1'b0;
  endtask

  task automatic drain(input int n, input logic ends);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = q.pop_front();
      chk("R2", "valid", int'(fr_valid), 1);
      chk("R2", "data", int'(fr_data), int'(e));
      chk("R3", "last", int'(fr_last), int'(ends && k == n-1));
      fr_ready = 1'b1;
      tick();
    end
    fr_ready = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_wr_en = 0; cpu_wr_data = 0; blk_commit = 0; blk_last = 0;
    tx_reset = 0; udr_ack = 0; fr_ready = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1", "pool_ready", int'(pool_ready), 1);
    chk("R1", "udr_irq", int'(udr_irq), 0);
    chk("R1", "fr_valid", int'(fr_valid), 0);
    chk("R1", "fr_last", int'(fr_last), 0);
    chk("R1", "fr_abort", int'(fr_abort), 0);

    // Sweep every single-block frame length
    for (int n = 1; n <= BLK; n++) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        b = 8'((n * 13 + i * 7 + 1) & 255);
        q.push_back(b);
        wr(b);
      end
      commit(1'b1);
      chk("R6", "pool after closing commit", int'(pool_ready), 0);
      drain(n, 1'b1);
      chk("R6", "pool after frame", int'(pool_ready), 1);
      fr_ready = 1'b1;
      tick(); tick();
      chk("R3", "no abort after frame end", int'(fr_abort), 0);
      chk("R3", "no irq after frame end", int'(udr_irq), 0);
      chk("R3", "valid after frame end", int'(fr_valid), 0);
      fr_ready = 1'b0;
    end

    // R4: overfilled block drops extra bytes
    for (int i = 0; i < BLK + 3; i++) begin
      logic [7:0] b;
      b = 8'(200 + i);
      if (i < BLK) q.push_back(b);
      wr(b);
    end
    commit(1'b1);
    drain(BLK, 1'b1);
    chk("R4", "valid after capped block", int'(fr_valid), 0);

    // R5 / R11: two-block store
    for (int i = 0; i < BLK; i++) begin q.push_back(8'(i)); wr(8'(i)); end
    commit(1'b0);
    chk("R5", "pool with one block held", int'(pool_ready), 1);
    for (int i = 0; i < BLK; i++) begin q.push_back(8'(64 + i)); wr(8'(64 + i)); end
    commit(1'b0);
    chk("R5", "pool with two blocks held", int'(pool_ready), 0);
    wr(8'hEE);
    commit(1'b1);
    chk("R11", "closing commit ignored", int'(fr_last), 0);
    drain(31, 1'b0);
    chk("R5", "pool with 33 held", int'(pool_ready), 0);
    drain(1, 1'b0);
    chk("R5", "pool with 32 held", int'(pool_ready), 1);
    q.push_back(8'h5A);
    wr(8'h5A);
    commit(1'b1);
    drain(33, 1'b1);
    chk("R11", "no stray byte", int'(fr_valid), 0);

    // R7: underrun
    for (int i = 0; i < 4; i++) begin q.push_back(8'(90 + i)); wr(8'(90 + i)); end
    commit(1'b0);
    drain(4, 1'b0);
    chk("R7", "abort before request", int'(fr_abort), 0);
    fr_ready = 1'b1;
    tick();
    chk("R7", "abort pulse", int'(fr_abort), 1);
    chk("R7", "irq raised", int'(udr_irq), 1);
    chk("R8", "pool locked", int'(pool_ready), 0);
    fr_ready = 1'b0;
    tick();
    chk("R7", "abort one cycle", int'(fr_abort), 0);
    chk("R7", "irq held", int'(udr_irq), 1);

    // R8: lockout
    wr(8'h11);
    commit(1'b1);
    chk("R8", "no frame while locked", int'(fr_valid), 0);
    chk("R8", "irq still set", int'(udr_irq), 1);

    // R9: acknowledge
    udr_ack = 1'b1;
    tick();
    udr_ack = 1'b0;
    chk("R9", "irq cleared", int'(udr_irq), 0);
    chk("R9", "pool back", int'(pool_ready), 1);
    q.push_back(8'h22);
    wr(8'h22);
    commit(1'b1);
    drain(1, 1'b1);

    // R10: transmit reset flushes committed and open data
    for (int i = 0; i < 3; i++) wr(8'(150 + i));
    commit(1'b0);
    chk("R2", "valid after commit", int'(fr_valid), 1);
    wr(8'h31); wr(8'h32);
    tx_reset = 1'b1;
    tick();
    tx_reset = 1'b0;
    chk("R10", "valid after reset", int'(fr_valid), 0);
    chk("R10", "pool after reset", int'(pool_ready), 1);
    fr_ready = 1'b1;
    tick();
    chk("R10", "frame closed by reset", int'(fr_abort), 0);
    fr_ready = 1'b0;

    // R10: reset lifts an underrun lock
    q.push_back(8'h44);
    wr(8'h44);
    commit(1'b0);
    drain(1, 1'b0);
    fr_ready = 1'b1;
    tick();
    fr_ready = 1'b0;
    chk("R7", "second underrun", int'(udr_irq), 1);
    tx_reset = 1'b1;
    tick();
    tx_reset = 1'b0;
    chk("R10", "irq cleared by reset", int'(udr_irq), 0);
    chk("R10", "pool after lock reset", int'(pool_ready), 1);
    q.push_back(8'h77);
    wr(8'h77);
    commit(1'b1);
    drain(1, 1'b1);
    chk("R10", "valid at end", int'(fr_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule